// File: doc/BRIEF.md
# PC Card Bus Access Controller

This controller sits between an internal request port and a PC-card style socket. It turns each request into a card memory cycle or a card I/O cycle. Any number of address regions (two by default) can each be switched on as a card window. Every region carries its own setup, software-wait and hold counts, so that address, card enables and write data meet card timing even when the bus clock is fast. A cycle's strobe phase is first stretched by the software wait count and then by an active-low external WAIT line.

A requester raises `req_valid` with a region number, a memory/I-O flag, a direction, a 26-bit address, two byte enables and write data. It holds these until `req_ready` pulses, which happens in the last cycle of the access. Read data is then valid on `rsp_rdata`. The low byte lane D7..D0 is selected by one card enable and the high lane D15..D8 by the other. A 16-bit I/O access to an 8-bit card port runs as two byte cycles.

Top module: `cardbus_ctrl`

## Requirements
- R1: A request whose region has its `cfg_window_en` bit clear causes no card enable and no strobe. `req_ready` pulses in the first cycle after acceptance, and `rsp_rdata` reads 0.
- R2: The counts of region r are taken from bits [4r+3:4r] of `cfg_setup`, `cfg_wait` and `cfg_hold`. The region named by `req_region` at acceptance sets the timing of that access.
- R3: With a setup count S, address, card enables and write data are driven for S cycles with every strobe high, starting in the first cycle after acceptance. They stay unchanged while the strobe is low.
- R4: With a software wait count W, the strobe is low for at least W+1 cycles. WAIT is ignored in the first W strobe cycles.
- R5: From strobe cycle W+1 onward, each cycle in which `card_wait_n` is sampled low adds one strobe cycle. The strobe rises after the first such cycle in which it is sampled high.
- R6: With a hold count H, address, enables and write data stay driven for H+1 cycles after the strobe rises. `req_ready` is high for exactly the last of these cycles.
- R7: The strobe is `card_mem_rd_n` for a memory read, `card_mem_wr_n` for a memory write, `card_io_rd_n` for an I/O read and `card_io_wr_n` for an I/O write. No more than one is low at a time.
- R8: `card_ce_lo_n` is low when `req_be[0]` is set and `card_ce_hi_n` is low when `req_be[1]` is set. `card_addr` equals `req_addr`. On writes `card_wdata` carries `req_wdata` with `card_wdata_oe` high.
- R9: Read data is taken from `card_rdata` at the last strobe-low clock edge. Bytes whose enable is clear read 0, and writes return 0.
- R10: An I/O request with `req_be`=2'b11 and `card_io16_n` high at acceptance runs as two complete cycles on the low lane only, with card address bit 0 at 0 and then 1. The low and then the high write byte go out on D7..D0, with D15..D8 at 0. The two read bytes form `rsp_rdata` {second, first}, and `req_ready` pulses only after the second cycle.
- R11: When no access is in progress, and after reset, all strobes and enables are high, `card_addr` and `card_wdata` are 0, `card_wdata_oe` is low and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_window_en | input | NREG | Card window enable per region |
| cfg_setup | input | NREG*4 | Setup count per region |
| cfg_wait | input | NREG*4 | Software wait count per region |
| cfg_hold | input | NREG*4 | Hold count per region |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completes this cycle |
| req_region | input | 1 | Region number |
| req_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_we | input | 1 | 1 = write |
| req_addr | input | 26 | Byte address |
| req_be | input | 2 | Byte enables (bit 0 low lane) |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data |
| card_addr | output | 26 | Card address |
| card_ce_lo_n | output | 1 | Low lane card enable |
| card_ce_hi_n | output | 1 | High lane card enable |
| card_mem_rd_n | output | 1 | Memory read strobe |
| card_mem_wr_n | output | 1 | Memory write strobe |
| card_io_rd_n | output | 1 | I/O read strobe |
| card_io_wr_n | output | 1 | I/O write strobe |
| card_wdata | output | 16 | Data driven toward the card |
| card_wdata_oe | output | 1 | Data output enable |
| card_rdata | input | 16 | Data from the card |
| card_wait_n | input | 1 | Wait request, active low |
| card_io16_n | input | 1 | Low when the I/O port is 16 bits wide |

## Verification
Two events can fall in the same cycle: the end of the software wait count and the sampling of WAIT. The bench provokes this by pulling `card_wait_n` low in exactly the strobe cycle where the software count runs out. It also pulls WAIT low only during the counted wait, and must then see no extension. A third case releases WAIT on the same edge that captures read data. The reference model predicts every output cycle from the counts and the WAIT schedule it drives. Each cycle is compared against the design, so an extension that is one cycle too early or too late shows up as a strobe mismatch.

// File: rtl/cardbus_pkg.sv
package cardbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ACT   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_t;

  // strobe index: 0 mem read, 1 mem write, 2 io read, 3 io write
  function automatic logic [3:0] strobe_onehot(input logic io, input logic we);
    logic [3:0] v;
    v = 4'b0000;
    v[{io, we}] = 1'b1;
    return v;
  endfunction

  function automatic phase_t entry_phase(input logic no_setup);
    return no_setup ? PH_ACT : PH_SETUP;
  endfunction

  function automatic logic wants_split(input logic io, input logic [1:0] be,
                                       input logic io16_n);
    return io && (be == 2'b11) && io16_n;
  endfunction

  // active-high lane enables {hi, lo}
  function automatic logic [1:0] lane_enables(input logic [1:0] be, input logic split);
    return split ? 2'b01 : be;
  endfunction

endpackage

// File: rtl/cardbus_seq.sv
module cardbus_seq
  import cardbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             skip,
  input  logic             split_in,
  input  logic [CNT_W-1:0] setup_in,
  input  logic [CNT_W-1:0] wait_in,
  input  logic [CNT_W-1:0] hold_in,
  input  logic             wait_n,
  output phase_t           phase,
  output logic             half,
  output logic             split,
  output logic             done,
  output logic             cap_edge
);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] s_q, w_q, h_q;
  logic             half_q, split_q;

  logic sw_expired, act_done, hold_last, second_due;

  assign sw_expired = (phase_q == PH_ACT) && (cnt_q == w_q);
  assign act_done   = sw_expired && wait_n;
  assign hold_last  = (phase_q == PH_HOLD) && (cnt_q == h_q);
  assign second_due = split_q && !half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      s_q     <= '0;
      w_q     <= '0;
      h_q     <= '0;
      half_q  <= 1'b0;
      split_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cnt_q  <= '0;
          half_q <= 1'b0;
          if (start) begin
            s_q     <= setup_in;
            w_q     <= wait_in;
            h_q     <= hold_in;
            split_q <= split_in;
            phase_q <= entry_phase(setup_in == '0);
          end else if (skip) begin
            split_q <= 1'b0;
            phase_q <= PH_SKIP;
          end
        end
        PH_SETUP: begin
          if (cnt_q == s_q - 1'b1) begin
            cnt_q   <= '0;
            phase_q <= PH_ACT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ACT: begin
          if (act_done) begin
            cnt_q   <= '0;
            phase_q <= PH_HOLD;
          end else if (!sw_expired) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD: begin
          if (hold_last) begin
            cnt_q <= '0;
            if (second_due) begin
              half_q  <= 1'b1;
              phase_q <= entry_phase(s_q == '0);
            end else begin
              phase_q <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SKIP: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = phase_q;
  assign half     = half_q;
  assign split    = split_q;
  assign cap_edge = act_done;
  assign done     = (hold_last && !second_due) || (phase_q == PH_SKIP);

endmodule

// File: rtl/cardbus_lanes.sv
module cardbus_lanes
  import cardbus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  phase_t             phase,
  input  logic               half,
  input  logic               split,
  input  logic               io,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         be,
  input  logic [DATA_W-1:0]  wdata,
  output logic [ADDR_W-1:0]  card_addr,
  output logic               ce_lo_n,
  output logic               ce_hi_n,
  output logic [3:0]         strobe_n,
  output logic [DATA_W-1:0]  card_wdata,
  output logic               card_wdata_oe,
  output logic               bus_active,
  output logic               strobe_on
);

  logic [1:0]        lanes;
  logic [LANE_W-1:0] byte_sel;

  assign bus_active = (phase == PH_SETUP) || (phase == PH_ACT) || (phase == PH_HOLD);
  assign strobe_on  = (phase == PH_ACT);
  assign lanes      = bus_active ? lane_enables(be, split) : 2'b00;
  assign ce_lo_n    = !lanes[0];
  assign ce_hi_n    = !lanes[1];
  assign strobe_n   = strobe_on ? ~strobe_onehot(io, we) : 4'b1111;
  assign byte_sel   = half ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];

  always_comb begin
    card_addr = '0;
    if (bus_active)
      card_addr = split ? {addr[ADDR_W-1:1], half} : addr;
  end

  always_comb begin
    card_wdata = '0;
    if (bus_active && we)
      card_wdata = split ? {{LANE_W{1'b0}}, byte_sel} : wdata;
  end

  assign card_wdata_oe = bus_active && we;

endmodule

// File: rtl/cardbus_ctrl.sv
module cardbus_ctrl
  import cardbus_pkg::*;
#(
  parameter int NREG   = 2,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 26,
  parameter int LANE_W = 8,
  localparam int REG_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       cfg_window_en,
  input  logic [NREG*CNT_W-1:0] cfg_setup,
  input  logic [NREG*CNT_W-1:0] cfg_wait,
  input  logic [NREG*CNT_W-1:0] cfg_hold,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [REG_W-1:0]      req_region,
  input  logic                  req_io,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     card_addr,
  output logic                  card_ce_lo_n,
  output logic                  card_ce_hi_n,
  output logic                  card_mem_rd_n,
  output logic                  card_mem_wr_n,
  output logic                  card_io_rd_n,
  output logic                  card_io_wr_n,
  output logic [DATA_W-1:0]     card_wdata,
  output logic                  card_wdata_oe,
  input  logic [DATA_W-1:0]     card_rdata,
  input  logic                  card_wait_n,
  input  logic                  card_io16_n
);

  phase_t            phase;
  logic              half, split, cap_edge, done;
  logic              accept, win_hit, start, skip, split_req;
  logic              bus_active, strobe_on, skip_cyc;
  logic [3:0]        strobe_n;
  logic [CNT_W-1:0]  setup_sel, wait_sel, hold_sel;

  logic              io_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign accept    = (phase == PH_IDLE) && req_valid;
  assign win_hit   = cfg_window_en[req_region];
  assign start     = accept && win_hit;
  assign skip      = accept && !win_hit;
  assign split_req = wants_split(req_io, req_be, card_io16_n);
  assign skip_cyc  = (phase == PH_SKIP);

  assign setup_sel = cfg_setup[req_region*CNT_W +: CNT_W];
  assign wait_sel  = cfg_wait[req_region*CNT_W +: CNT_W];
  assign hold_sel  = cfg_hold[req_region*CNT_W +: CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      io_q    <= req_io;
      we_q    <= req_we;
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (accept) begin
      rdata_q <= '0;
    end else if (cap_edge && !we_q) begin
      if (!split)
        rdata_q <= card_rdata & {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};
      else if (half)
        rdata_q[DATA_W-1:LANE_W] <= card_rdata[LANE_W-1:0];
      else
        rdata_q[LANE_W-1:0] <= card_rdata[LANE_W-1:0];
    end
  end

  cardbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .skip     (skip),
    .split_in (split_req),
    .setup_in (setup_sel),
    .wait_in  (wait_sel),
    .hold_in  (hold_sel),
    .wait_n   (card_wait_n),
    .phase    (phase),
    .half     (half),
    .split    (split),
    .done     (done),
    .cap_edge (cap_edge)
  );

  cardbus_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lanes (
    .phase         (phase),
    .half          (half),
    .split         (split),
    .io            (io_q),
    .we            (we_q),
    .addr          (addr_q),
    .be            (be_q),
    .wdata         (wdata_q),
    .card_addr     (card_addr),
    .ce_lo_n       (card_ce_lo_n),
    .ce_hi_n       (card_ce_hi_n),
    .strobe_n      (strobe_n),
    .card_wdata    (card_wdata),
    .card_wdata_oe (card_wdata_oe),
    .bus_active    (bus_active),
    .strobe_on     (strobe_on)
  );

  assign card_mem_rd_n = strobe_n[0];
  assign card_mem_wr_n = strobe_n[1];
  assign card_io_rd_n  = strobe_n[2];
  assign card_io_wr_n  = strobe_n[3];
  assign req_ready     = done;
  assign rsp_rdata     = rdata_q;

endmodule

// File: rtl/cardbus_chk.sv
module cardbus_chk #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] card_addr,
  input logic [DATA_W-1:0] card_wdata,
  input logic              card_ce_lo_n,
  input logic              card_ce_hi_n,
  input logic              card_mem_rd_n,
  input logic              card_mem_wr_n,
  input logic              card_io_rd_n,
  input logic              card_io_wr_n,
  input logic              card_wdata_oe,
  input logic              bus_active,
  input logic              strobe_on,
  input logic              skip_cyc,
  input logic              cap_edge
);

  logic [3:0] stb_act;
  assign stb_act = {~card_io_wr_n, ~card_io_rd_n, ~card_mem_wr_n, ~card_mem_rd_n};

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stb_act) <= 1);

  p_strobe_has_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_act != 4'b0) |-> (!card_ce_lo_n || !card_ce_hi_n));

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> ($stable(card_addr) && $stable(card_wdata)));

  p_hold_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_on && $past(strobe_on)) |->
      ($stable(card_addr) && $stable(card_ce_lo_n) && $stable(card_ce_hi_n)));

  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_capture_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |=> !strobe_on);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> (stb_act == 4'b0 && card_ce_lo_n && card_ce_hi_n && !card_wdata_oe));

  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    skip_cyc |-> (req_ready && card_ce_lo_n && card_ce_hi_n && stb_act == 4'b0));

endmodule

bind cardbus_ctrl cardbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .card_addr     (card_addr),
  .card_wdata    (card_wdata),
  .card_ce_lo_n  (card_ce_lo_n),
  .card_ce_hi_n  (card_ce_hi_n),
  .card_mem_rd_n (card_mem_rd_n),
  .card_mem_wr_n (card_mem_wr_n),
  .card_io_rd_n  (card_io_rd_n),
  .card_io_wr_n  (card_io_wr_n),
  .card_wdata_oe (card_wdata_oe),
  .bus_active    (bus_active),
  .strobe_on     (strobe_on),
  .skip_cyc      (skip_cyc),
  .cap_edge      (cap_edge)
);

// File: tb/test_cardbus_ctrl.sv
module test_cardbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_window_en = 2'b11;
  logic [7:0]  cfg_setup = '0, cfg_wait = '0, cfg_hold = '0;
  logic        req_valid = 1'b0, req_ready;
  logic        req_region = 1'b0, req_io = 1'b0, req_we = 1'b0;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, rsp_rdata;
  logic [25:0] card_addr;
  logic        card_ce_lo_n, card_ce_hi_n;
  logic        card_mem_rd_n, card_mem_wr_n, card_io_rd_n, card_io_wr_n;
  logic [15:0] card_wdata, card_rdata = '0;
  logic        card_wdata_oe;
  logic        card_wait_n = 1'b1, card_io16_n = 1'b0;

  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  cardbus_ctrl i_cardbus_ctrl (
    .clk, .rst_n, .cfg_window_en, .cfg_setup, .cfg_wait, .cfg_hold,
    .req_valid, .req_ready, .req_region, .req_io, .req_we, .req_addr,
    .req_be, .req_wdata, .rsp_rdata, .card_addr, .card_ce_lo_n, .card_ce_hi_n,
    .card_mem_rd_n, .card_mem_wr_n, .card_io_rd_n, .card_io_wr_n,
    .card_wdata, .card_wdata_oe, .card_rdata, .card_wait_n, .card_io16_n
  );

  typedef struct {
    logic [25:0] addr;
    logic        ce_lo_n, ce_hi_n;
    logic [3:0]  stb_n;    // {io_wr, io_rd, mem_wr, mem_rd}
    logic [15:0] wd;
    logic        oe, rdy, wait_n;
    logic [15:0] rd;
  } cyc_t;

  cyc_t model_q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic cyc_t idle_cyc();
    cyc_t c;
    c.addr = '0; c.ce_lo_n = 1; c.ce_hi_n = 1; c.stb_n = 4'hF; c.wd = '0;
    c.oe = 0; c.rdy = 0; c.wait_n = 1; c.rd = '0;
    return c;
  endfunction

  task automatic compare_cycle(input cyc_t e, input string tag);
    logic [3:0] stb;
    stb = {card_io_wr_n, card_io_rd_n, card_mem_wr_n, card_mem_rd_n};
    check({card_addr, card_ce_lo_n, card_ce_hi_n, card_wdata, card_wdata_oe} ===
          {e.addr, e.ce_lo_n, e.ce_hi_n, e.wd, e.oe},
          {tag, " R3/R6/R8 addr,ce,data"},
          {19'd0, card_addr, card_ce_lo_n, card_ce_hi_n, card_wdata, card_wdata_oe},
          {19'd0, e.addr, e.ce_lo_n, e.ce_hi_n, e.wd, e.oe});
    check(stb === e.stb_n, {tag, " R4/R5/R7 strobes"}, 64'(stb), 64'(e.stb_n));
    check(req_ready === e.rdy, {tag, " R6 ready"}, 64'(req_ready), 64'(e.rdy));
  endtask

  // one card cycle: S setup, 1+W+hw strobe, H+1 hold cycles
  task automatic push_half(input cyc_t base, input logic [3:0] stb_on,
                           input int s, input int w, input int h, input int hw,
                           input bit early, input bit last);
    cyc_t c;
    for (int i = 0; i < s; i++) begin
      c = base; c.stb_n = 4'hF; c.rdy = 0; c.wait_n = early ? 1'b0 : 1'b1;
      model_q.push_back(c);
    end
    for (int i = 0; i < 1 + w + hw; i++) begin
      c = base; c.stb_n = stb_on; c.rdy = 0;
      c.wait_n = ((i >= w) && (i < w + hw)) ? 1'b0 : ((early && i < w) ? 1'b0 : 1'b1);
      model_q.push_back(c);
    end
    for (int i = 0; i <= h; i++) begin
      c = base; c.stb_n = 4'hF; c.rdy = last && (i == h); c.wait_n = 1;
      model_q.push_back(c);
    end
  endtask

  task automatic run_txn(input int r, input bit io, input bit we, input logic [25:0] a,
                         input logic [1:0] be, input logic [15:0] wd, input int hw,
                         input bit early, input bit io16_n, input logic [15:0] rd0,
                         input logic [15:0] rd1, input string tag);
    int s, w, h, idx;
    bit split;
    logic [3:0] stb_on;
    logic [15:0] exp_rd;
    cyc_t base, e;
    s = int'(cfg_setup[r*4 +: 4]);   // R2 field position
    w = int'(cfg_wait[r*4 +: 4]);
    h = int'(cfg_hold[r*4 +: 4]);
    split = io && (be == 2'b11) && io16_n;
    idx = (io ? 2 : 0) + (we ? 1 : 0);
    stb_on = 4'hF; stb_on[idx] = 1'b0;
    model_q.delete();
    if (!cfg_window_en[r]) begin        // R1 no window
      e = idle_cyc(); e.rdy = 1; model_q.push_back(e);
      exp_rd = '0;
    end else begin
      for (int hh = 0; hh < (split ? 2 : 1); hh++) begin
        base = idle_cyc();
        base.addr    = split ? {a[25:1], hh[0]} : a;
        base.ce_lo_n = split ? 1'b0 : !be[0];
        base.ce_hi_n = split ? 1'b1 : !be[1];
        base.wd      = !we ? 16'h0 : (split ? {8'h00, (hh == 1 ? wd[15:8] : wd[7:0])} : wd);
        base.oe      = we;
        base.rd      = (hh == 1) ? rd1 : rd0;
        push_half(base, stb_on, s, w, h, hw, early, (hh == (split ? 1 : 0)));
      end
      if (we) exp_rd = '0;
      else if (split) exp_rd = {rd1[7:0], rd0[7:0]};
      else exp_rd = rd0 & {{8{be[1]}}, {8{be[0]}}};
    end
    @(negedge clk);
    req_valid = 1; req_region = r[0]; req_io = io; req_we = we; req_addr = a;
    req_be = be; req_wdata = wd; card_io16_n = io16_n;
    while (model_q.size() > 0) begin
      @(negedge clk);
      e = model_q.pop_front();
      compare_cycle(e, tag);
      card_wait_n = e.wait_n;
      card_rdata  = e.rd;
      if (e.rdy) begin
        check(rsp_rdata === exp_rd, {tag, " R9 read data"}, 64'(rsp_rdata), 64'(exp_rd));
        req_valid = 0;
      end
    end
    card_wait_n = 1;
    @(negedge clk);
    compare_cycle(idle_cyc(), {tag, " R11 idle after"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_cycle(idle_cyc(), "R11 reset");
    check(rsp_rdata === 16'h0, "R11 reset rdata", 64'(rsp_rdata), 64'h0);
    rst_n = 1;
    @(negedge clk);
    // region 0: S2 W1 H1 ; region 1: S0 W3 H0  (R2)
    cfg_setup = 8'h02; cfg_wait = 8'h31; cfg_hold = 8'h01;
    run_txn(0, 0, 0, 26'h1234567, 2'b11, 16'h0, 0, 0, 0, 16'hBEEF, 16'h0, "R2 R3 R7 mem rd r0");
    run_txn(1, 0, 1, 26'h0000AA1, 2'b01, 16'hA55A, 0, 0, 0, 16'h0, 16'h0, "R2 R8 mem wr r1 lo");
    run_txn(0, 0, 0, 26'h2000002, 2'b10, 16'h0, 3, 0, 0, 16'hC3D4, 16'h0, "R5 R9 wait ext hi");
    cfg_setup = 8'h01; cfg_wait = 8'h04;
    run_txn(0, 0, 1, 26'h0000100, 2'b11, 16'h1357, 0, 1, 0, 16'h0, 16'h0, "R4 early wait ignored");
    cfg_wait = 8'h02;
    run_txn(0, 0, 0, 26'h0000200, 2'b11, 16'h0, 1, 0, 0, 16'h8001, 16'h0, "R5 wait at expiry");
    run_txn(0, 1, 0, 26'h0000301, 2'b10, 16'h0, 0, 0, 0, 16'h7E81, 16'h0, "R7 R9 io rd hi");
    run_txn(1, 1, 1, 26'h0000302, 2'b11, 16'hF00F, 0, 0, 0, 16'h0, 16'h0, "R7 io wr 16");
    run_txn(0, 1, 0, 26'h0000404, 2'b11, 16'h0, 1, 0, 1, 16'h0012, 16'h0034, "R10 io rd split");
    run_txn(1, 1, 1, 26'h0000406, 2'b11, 16'hCAFE, 0, 0, 1, 16'h0, 16'h0, "R10 io wr split");
    run_txn(0, 0, 0, 26'h0000500, 2'b01, 16'h0, 0, 0, 1, 16'h1111, 16'h0, "R10 mem ignores io16");
    cfg_window_en = 2'b01;
    run_txn(1, 0, 0, 26'h0000600, 2'b11, 16'h0, 0, 0, 0, 16'hFFFF, 16'h0, "R1 no window");
    cfg_window_en = 2'b11;
    cfg_setup = 8'hF0; cfg_wait = 8'hF0; cfg_hold = 8'hF0;
    run_txn(1, 0, 0, 26'h3FFFFFF, 2'b11, 16'h0, 2, 0, 0, 16'h5AA5, 16'h0, "R2 R3 R6 max counts");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule